// File: doc/BRIEF.md
# Nested-Loop Strided Address Generator

This block produces the word address stream for one operand of a tiled, bit-serial matrix or convolution job. Software-facing setup is outside its scope: a controller presents a base address, one signed jump and one loop length per nesting level, and a total step count, then pulses `start`. From then on the block emits one address per cycle that is not stalled, with a valid flag beside it. It stops after the programmed number of addresses and then raises a one-cycle `done`.

Inside, the levels are chained counters. The innermost level advances on every emitted address. A level that reaches its programmed limit while every level below it is also at its limit wraps to zero and lets the next level advance. When any level wraps, the jump of the outermost wrapping level is added to the address in place of the default step of one. Jumps may be negative, so the stream can step back over tiles, revisit bit-plane pairs or slide a kernel window. The address wraps at the memory width. Only the step count ends the job; the loop nest wrapping all the way round does not.

Top module: `strided_agen`

## Requirements
- R1: While and after reset, `addr_valid`, `busy` and `done` are low.
- R2: A `start` pulse taken while idle loads the base address, and the first valid address of the job equals that base.
- R3: When no level wraps, the next address is the previous address plus one.
- R4: Each level's length field holds its iteration count minus one. Level 0 advances on every emitted address. Level k (k > 0) advances only when levels 0 to k-1 all wrap. A level at its limit wraps to zero instead of advancing.
- R5: When one or more levels wrap on a step, the signed two's-complement jump of the highest-numbered wrapping level is added in place of the step of one. Level k's jump sits at bits [k*JUMP_W +: JUMP_W] of `level_jump`, and its length sits at bits [k*LEN_W +: LEN_W] of `level_len`.
- R6: Address arithmetic wraps modulo 2^ADDR_W, both upward and below zero.
- R7: A job emits exactly `step_total` valid addresses. A total of zero emits none and still ends with `done`.
- R8: `done` is high for exactly one cycle: the cycle right after the last valid address. For a zero-length job it comes without any valid address. `addr_valid` is low while `done` is high.
- R9: If `stall` is high at a clock edge while the block is busy, `addr_valid` is low in the following cycle. The address and all counters hold, and the sequence then resumes with no address lost or repeated.
- R10: A `start` pulse while busy is ignored, and the running sequence continues unchanged.
- R11: Base, lengths, jumps and total are captured at start. Changes on those inputs during a job do not alter its sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job (accepted only while idle) |
| stall | input | 1 | Freeze the generator for this cycle |
| base_addr | input | ADDR_W | First address of the job |
| level_len | input | LEVELS*LEN_W | Per-level iteration count minus one |
| level_jump | input | LEVELS*JUMP_W | Per-level signed jump applied on wrap |
| step_total | input | CNT_W | Number of addresses the job emits |
| addr_out | output | ADDR_W | Registered address |
| addr_valid | output | 1 | `addr_out` holds a job address this cycle |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse after the last address |

## Verification
The bench targets the cascade corners. These include wrapping every level at once, where a wrong priority would add an inner level's jump, and length fields of zero and one, where an off-by-one in the count-minus-one encoding would shift every later jump by a step. Negative jumps that take the address below zero check the modular arithmetic; a design that saturated or sign-extended wrongly would emit addresses outside the expected ring. Periodic and long stalls would expose a design that drops or repeats an address while frozen. Zero and single-step totals, a start pulse mid-job and input changes mid-job show whether `done` is late, repeated or missing, and whether the running sequence is corrupted.

// File: rtl/agen_pkg.sv
package agen_pkg;

  typedef enum logic {
    AG_IDLE = 1'b0,
    AG_RUN  = 1'b1
  } ag_state_e;

endpackage

// File: rtl/agen_level.sv
module agen_level #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] len_in,
  input  logic             advance,
  input  logic             carry_in,
  output logic             wrap
);

  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] count_q;

  assign wrap = carry_in && (count_q == len_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q   <= '0;
      count_q <= '0;
    end else if (load) begin
      len_q   <= len_in;
      count_q <= '0;
    end else if (advance && carry_in) begin
      count_q <= wrap ? '0 : count_q + LEN_W'(1);
    end
  end

  // R4: the counter never passes its programmed limit
  a_r4_count_in_range: assert property (@(posedge clk) disable iff (rst)
    count_q <= len_q);

  // R4: a wrapping level restarts at zero
  a_r4_wrap_restarts: assert property (@(posedge clk) disable iff (rst)
    (advance && wrap && !load) |=> (count_q == '0));

endmodule

// File: rtl/agen_step_sel.sv
module agen_step_sel #(
  parameter int LEVELS = 5,
  parameter int JUMP_W = 12,
  parameter int SUM_W  = 13
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [LEVELS-1:0]          wrap,
  input  logic [LEVELS*JUMP_W-1:0]   jumps,
  output logic signed [SUM_W-1:0]    step
);

  localparam int EXT_W = SUM_W - JUMP_W;

  logic [LEVELS-1:0] sel;

  // outermost wrapping level wins: later iterations overwrite earlier ones
  always_comb begin
    sel = '0;
    for (int k = 0; k < LEVELS; k++) begin
      if (wrap[k]) begin
        sel    = '0;
        sel[k] = 1'b1;
      end
    end
  end

  always_comb begin
    step = SUM_W'(1);
    for (int k = 0; k < LEVELS; k++) begin
      if (sel[k]) begin
        step = $signed({{EXT_W{jumps[k*JUMP_W+JUMP_W-1]}}, jumps[k*JUMP_W +: JUMP_W]});
      end
    end
  end

  // R5: at most one jump is selected per step
  a_r5_single_jump: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));

  // R5: a jump is only taken from a level that actually wrapped
  a_r5_jump_from_wrap: assert property (@(posedge clk) disable iff (rst)
    (sel & ~wrap) == '0);

endmodule

// File: rtl/agen_countdown.sv
module agen_countdown #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] total,
  input  logic             dec,
  output logic             is_zero,
  output logic             is_last
);

  logic [CNT_W-1:0] remain_q;

  assign is_zero = (remain_q == '0);
  assign is_last = (remain_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= total;
    end else if (dec) begin
      remain_q <= remain_q - CNT_W'(1);
    end
  end

  // R7: each emitted address removes exactly one step
  a_r7_dec_by_one: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |=> (remain_q == $past(remain_q) - CNT_W'(1)));

  // R7: no address is emitted once the count is used up
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
    dec |-> !is_zero);

endmodule

// File: rtl/strided_agen.sv
module strided_agen
  import agen_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LEVELS = 5,
  parameter int LEN_W  = 8,
  parameter int JUMP_W = 12,
  parameter int CNT_W  = 20
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     stall,
  input  logic [ADDR_W-1:0]        base_addr,
  input  logic [LEVELS*LEN_W-1:0]  level_len,
  input  logic [LEVELS*JUMP_W-1:0] level_jump,
  input  logic [CNT_W-1:0]         step_total,
  output logic [ADDR_W-1:0]        addr_out,
  output logic                     addr_valid,
  output logic                     busy,
  output logic                     done
);

  localparam int SUM_W = ((ADDR_W > JUMP_W) ? ADDR_W : JUMP_W) + 1;
  localparam int PAD_W = SUM_W - ADDR_W;

  ag_state_e               state_q;
  logic [ADDR_W-1:0]       cur_q;
  logic [LEVELS*JUMP_W-1:0] jumps_q;
  logic                    last_q;

  logic                    accept;
  logic                    emit;
  logic                    fin_zero;
  logic                    cnt_zero;
  logic                    cnt_last;
  logic [LEVELS-1:0]       wrap;
  logic [LEVELS-1:0]       carry;
  logic signed [SUM_W-1:0] step;
  logic signed [SUM_W-1:0] sum;
  logic [ADDR_W-1:0]       next_addr;

  assign busy     = (state_q == AG_RUN);
  assign accept   = start && !busy;
  assign emit     = busy && !stall && !cnt_zero;
  assign fin_zero = busy && cnt_zero;

  genvar g;
  generate
    for (g = 0; g < LEVELS; g++) begin : g_lvl
      if (g == 0) begin : g_first
        assign carry[g] = 1'b1;
      end else begin : g_rest
        assign carry[g] = wrap[g-1];
      end
      agen_level #(.LEN_W(LEN_W)) u_lvl (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .len_in   (level_len[g*LEN_W +: LEN_W]),
        .advance  (emit),
        .carry_in (carry[g]),
        .wrap     (wrap[g])
      );
    end
  endgenerate

  agen_step_sel #(.LEVELS(LEVELS), .JUMP_W(JUMP_W), .SUM_W(SUM_W)) u_sel (
    .clk   (clk),
    .rst   (rst),
    .wrap  (wrap),
    .jumps (jumps_q),
    .step  (step)
  );

  agen_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .total   (step_total),
    .dec     (emit),
    .is_zero (cnt_zero),
    .is_last (cnt_last)
  );

  assign sum       = $signed({{PAD_W{1'b0}}, cur_q}) + step;
  assign next_addr = sum[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= AG_IDLE;
      cur_q      <= '0;
      jumps_q    <= '0;
      addr_out   <= '0;
      addr_valid <= 1'b0;
      last_q     <= 1'b0;
      done       <= 1'b0;
    end else begin
      addr_valid <= emit;
      last_q     <= (emit && cnt_last) || fin_zero;
      done       <= last_q;
      if (accept) begin
        state_q <= AG_RUN;
        cur_q   <= base_addr;
        jumps_q <= level_jump;
      end else if (emit) begin
        addr_out <= cur_q;
        cur_q    <= next_addr;
        if (cnt_last) state_q <= AG_IDLE;
      end else if (fin_zero) begin
        state_q <= AG_IDLE;
      end
    end
  end

  // R9: a stall seen while busy suppresses the next valid
  a_r9_stall_blocks_valid: assert property (@(posedge clk) disable iff (rst)
    (busy && stall) |=> !addr_valid);

  // R9: a stall seen while busy keeps the running address
  a_r9_stall_holds_addr: assert property (@(posedge clk) disable iff (rst)
    (busy && stall) |=> $stable(cur_q));

  // R8: done never lasts two cycles
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: done never coincides with a valid address
  a_r8_done_no_valid: assert property (@(posedge clk) disable iff (rst)
    done |-> !addr_valid);

  // R10: a start while busy does not reload the running address
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start && stall) |=> $stable(cur_q));

endmodule

// File: tb/strided_agen_tb_top.sv
module strided_agen_tb_top;

  localparam int ADDR_W = 12;
  localparam int LEVELS = 5;
  localparam int LEN_W  = 8;
  localparam int JUMP_W = 12;
  localparam int CNT_W  = 20;
  localparam int MAXN   = 512;

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic                     start = 1'b0;
  logic                     stall = 1'b0;
  logic [ADDR_W-1:0]        base_addr = '0;
  logic [LEVELS*LEN_W-1:0]  level_len = '0;
  logic [LEVELS*JUMP_W-1:0] level_jump = '0;
  logic [CNT_W-1:0]         step_total = '0;
  logic [ADDR_W-1:0]        addr_out;
  logic                     addr_valid;
  logic                     busy;
  logic                     done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int lens [LEVELS];
  int jmps [LEVELS];
  logic [ADDR_W-1:0] exp_a [MAXN];

  always #2 clk = ~clk;

  strided_agen #(
    .ADDR_W(ADDR_W), .LEVELS(LEVELS), .LEN_W(LEN_W), .JUMP_W(JUMP_W), .CNT_W(CNT_W)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .stall(stall),
    .base_addr(base_addr), .level_len(level_len), .level_jump(level_jump),
    .step_total(step_total), .addr_out(addr_out), .addr_valid(addr_valid),
    .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // reference from the requirements: nested counters, outermost wrap picks the jump
  task automatic build_expected(input logic [ADDR_W-1:0] base, input int total);
    int c [LEVELS];
    logic [ADDR_W-1:0] a;
    a = base;
    for (int k = 0; k < LEVELS; k++) c[k] = 0;
    for (int i = 0; i < total; i++) begin
      int outer;
      bit carry_b;
      exp_a[i] = a;
      outer = -1;
      carry_b = 1'b1;
      for (int k = 0; k < LEVELS; k++) begin
        if (carry_b) begin
          if (c[k] == lens[k]) begin
            c[k] = 0;
            outer = k;
          end else begin
            c[k] = c[k] + 1;
            carry_b = 1'b0;
          end
        end
      end
      if (outer < 0) a = a + ADDR_W'(1);
      else a = a + ADDR_W'(jmps[outer]);
    end
  endtask

  task automatic drive_cfg();
    for (int k = 0; k < LEVELS; k++) begin
      level_len[k*LEN_W +: LEN_W]    = LEN_W'(lens[k]);
      level_jump[k*JUMP_W +: JUMP_W] = JUMP_W'(jmps[k]);
    end
  endtask

  // stall_mode: 0 none, 1 every third cycle, 2 one long freeze
  // disturb: 0 none, 1 start pulse mid-job, 2 inputs changed mid-job
  task automatic run_job(input string tag, input logic [ADDR_W-1:0] base,
                         input int total, input int stall_mode, input int disturb);
    int idx;
    int cyc;
    bit done_seen;
    bit prev_valid;
    bit prev_stall;
    bit prev_busy;
    build_expected(base, total);
    @(negedge clk);
    drive_cfg();
    base_addr  = base;
    step_total = CNT_W'(total);
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idx = 0; cyc = 0; done_seen = 1'b0;
    prev_valid = 1'b0; prev_stall = 1'b0; prev_busy = 1'b1;
    while (!done_seen && cyc < 4000) begin
      @(negedge clk);
      cyc = cyc + 1;
      if (prev_stall && prev_busy)
        check(!addr_valid, "R9", "valid after stall", addr_valid, 0);
      if (addr_valid) begin
        if (idx < total) begin
          if (idx == 0)
            check(addr_out == base, "R2", "first address", addr_out, base);
          check(addr_out == exp_a[idx], tag, $sformatf("address %0d", idx),
                addr_out, exp_a[idx]);
        end else begin
          check(1'b0, "R7", "extra valid address", idx, total);
        end
        idx = idx + 1;
      end
      if (done) begin
        done_seen = 1'b1;
        check(idx == total, "R7", "address count at done", idx, total);
        check(!addr_valid, "R8", "valid together with done", addr_valid, 0);
        if (total > 0)
          check(prev_valid, "R8", "done right after last valid", prev_valid, 1);
      end
      prev_valid = addr_valid;
      prev_busy  = busy;
      case (stall_mode)
        1: stall = ((cyc % 3) == 1);
        2: stall = (cyc >= 5 && cyc < 17);
        default: stall = 1'b0;
      endcase
      prev_stall = stall;
      start = 1'b0;
      if (disturb == 1 && cyc == 4) begin
        start     = 1'b1;
        base_addr = ~base;
      end
      if (disturb == 2 && cyc == 3) begin
        base_addr  = base + ADDR_W'(100);
        step_total = CNT_W'(3);
        level_len  = '0;
        level_jump = {LEVELS{JUMP_W'(7)}};
      end
    end
    stall = 1'b0;
    start = 1'b0;
    check(done_seen, "R8", "done observed", done_seen, 1);
    @(negedge clk);
    check(!done, "R8", "done width one cycle", done, 0);
    check(!addr_valid, "R7", "no valid after done", addr_valid, 0);
    check(!busy, "R7", "idle after done", busy, 0);
  endtask

  task automatic t_reset();
    check(!addr_valid, "R1", "valid in reset", addr_valid, 0);
    check(!busy, "R1", "busy in reset", busy, 0);
    check(!done, "R1", "done in reset", done, 0);
  endtask

  task automatic t_linear();
    for (int k = 0; k < LEVELS; k++) begin lens[k] = 255; jmps[k] = 0; end
    run_job("R3", 12'h100, 10, 0, 0);
  endtask

  task automatic t_tiles();
    lens = '{1, 3, 1, 0, 0};
    jmps = '{30, 2, -6, 4, 0};
    run_job("R4", 12'h040, 40, 0, 0);
  endtask

  task automatic t_backward();
    lens = '{2, 1, 0, 0, 0};
    jmps = '{-64, -528, 100, 0, 0};
    run_job("R6", 12'h005, 24, 0, 0);
  endtask

  task automatic t_deep();
    lens = '{1, 1, 1, 1, 1};
    jmps = '{3, 5, 7, 11, -13};
    run_job("R5", 12'hFF0, 70, 0, 0);
  endtask

  task automatic t_zero();
    lens = '{1, 1, 0, 0, 0};
    jmps = '{5, 5, 5, 5, 5};
    run_job("R7", 12'h020, 0, 0, 0);
  endtask

  task automatic t_single();
    lens = '{0, 0, 0, 0, 0};
    jmps = '{9, 9, 9, 9, 9};
    run_job("R7", 12'h7FF, 1, 0, 0);
  endtask

  task automatic t_stall();
    lens = '{1, 3, 1, 0, 0};
    jmps = '{30, 2, -6, 4, 0};
    run_job("R9", 12'h300, 30, 1, 0);
    run_job("R9", 12'h010, 20, 2, 0);
  endtask

  task automatic t_restart();
    lens = '{2, 2, 0, 0, 0};
    jmps = '{-3, 20, 1, 1, 1};
    run_job("R10", 12'h080, 25, 0, 1);
  endtask

  task automatic t_cfg_hold();
    lens = '{3, 1, 0, 0, 0};
    jmps = '{-2, 64, 1, 1, 1};
    run_job("R11", 12'h200, 25, 0, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_linear();
    t_tiles();
    t_backward();
    t_deep();
    t_zero();
    t_single();
    t_stall();
    t_restart();
    t_cfg_hold();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule